// File: doc/BRIEF.md
# Multidrop receive address filter

This block sits between a UART receive deserializer and the receive FIFO on a 9-bit multidrop serial link. Each received character arrives with eight data bits and a ninth bit. The ninth bit arrives in the parity position and marks the character as an address (1) or as data (0).

When filtering mode is on, the block holds a receiver-on state that the hardware sets and clears by itself. An address equal to the programmed station address switches the receiver on. The matching address is stored in the FIFO, and a line-status interrupt request can be raised for it. Data characters are kept only while the receiver is on. An address that does not match switches the receiver off and is dropped. The host can also force the receiver off with a disable pulse.

When filtering mode is off, every character goes straight to the FIFO.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, `fifo_wr` and `irq_flag` are 0 and the receiver is off. A data character received in filtering mode straight after reset is therefore not written.
- R2: With `mode_en` = 0, every received character is written. The FIFO word is {`rx_perr`, `rx_data`}, with bit 8 as the error slot, whatever the value of `rx_ninth`.
- R3: With `mode_en` = 1 and the receiver off, data characters (`rx_ninth` = 0) and non-matching address characters (`rx_ninth` = 1) are not written.
- R4: An address character whose 8 data bits equal `station_addr` turns the receiver on. Data characters that follow are then written.
- R5: A matching address character is itself written. Bit 8 of its FIFO word holds its ninth bit, which is 1.
- R6: A data character accepted in filtering mode is stored with `rx_perr` in bit 8.
- R7: A matching address sets `irq_flag` only when `lsi_en` = 1. The flag stays set until an `irq_ack` pulse. If a set and an acknowledge fall in the same cycle, the flag is set.
- R8: While the receiver is on, a non-matching address character turns it off and is not written. Data characters after it are not written.
- R9: While the receiver is on, a further matching address is written again with bit 8 = 1, and the receiver stays on.
- R10: A `host_disable` pulse turns the receiver off. In the same cycle as a matching address, the disable wins: the address is still written, but the receiver ends up off.
- R11: `fifo_wr` is a single-cycle pulse, registered one clock after the `rx_valid` cycle it belongs to. It is never raised without `rx_valid`.
- R12: The match compares all 8 data bits. An address that differs from `station_addr` in a single bit is treated as a non-match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received data bits |
| rx_ninth | input | 1 | Ninth bit: 1 = address, 0 = data |
| rx_perr | input | 1 | Parity-error indication from the deserializer |
| mode_en | input | 1 | Enables address filtering |
| station_addr | input | 8 | Programmed station address |
| lsi_en | input | 1 | Line-status interrupt enable |
| host_disable | input | 1 | One-cycle pulse that turns the receiver off |
| irq_ack | input | 1 | One-cycle pulse that clears the interrupt flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_word | output | 9 | Word to store: bit 8 is the error slot, bits 7:0 are data |
| irq_flag | output | 1 | Line-status interrupt request |

## Verification
A vector table drives runs of characters that differ in mode, ninth bit, parity flag and address value.

- Pass-through characters with the ninth bit set separate the mode-off path from filtering.
- A single-bit-off address separates a full 8-bit compare from a partial one.
- Matching addresses sent with `lsi_en` low and then high separate the interrupt gating from the write path.

Directed tests cover the cases that depend on ordering: a host disable alone, a host disable together with a matching address, and an acknowledge together with a new interrupt. They also check that the write strobe falls back to 0 in the cycle after each write.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  // Per-character classification, one-hot when a strobe is present
  typedef struct packed {
    logic bypass;    // mode off: pass through
    logic data;      // filtering, ninth bit 0
    logic match;     // filtering, address equal to station
    logic mismatch;  // filtering, address not equal to station
  } mdf_evt_t;

endpackage

// File: rtl/mdf_classify.sv
module mdf_classify
  import mdf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ninth,
  input  logic              mode_en,
  input  logic [DATA_W-1:0] station_addr,
  output mdf_evt_t          evt
);

  function automatic logic addr_hit(input logic [DATA_W-1:0] d,
                                    input logic [DATA_W-1:0] a);
    return (d ^ a) == '0;
  endfunction

  logic filt;
  logic hit;

  assign filt = rx_valid && mode_en;
  assign hit  = addr_hit(rx_data, station_addr);

  always_comb begin
    evt.bypass   = rx_valid && !mode_en;
    evt.data     = filt && !rx_ninth;
    evt.match    = filt && rx_ninth && hit;
    evt.mismatch = filt && rx_ninth && !hit;
  end

  always_comb begin
    assert_evt_onehot_R3: assert ($onehot0(evt));
  end

endmodule

// File: rtl/mdf_gate.sv
module mdf_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_match,
  input  logic ev_mismatch,
  input  logic host_disable,
  output logic rx_on
);

  always_ff @(posedge clk) begin
    if (!rst_n)            rx_on <= 1'b0;
    else if (host_disable) rx_on <= 1'b0;
    else if (ev_match)     rx_on <= 1'b1;
    else if (ev_mismatch)  rx_on <= 1'b0;
  end

  assert_match_turns_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && !host_disable) |=> rx_on);

  assert_mismatch_turns_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> !rx_on);

  assert_host_disable_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_disable |=> !rx_on);

endmodule

// File: rtl/mdf_irq.sv
module mdf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ack,
  output logic irq_flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (set_req) irq_flag <= 1'b1;
    else if (ack)     irq_flag <= 1'b0;
  end

  assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(set_req));

  assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !ack) |=> irq_flag);

endmodule

// File: rtl/mdf_wstage.sv
module mdf_wstage #(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              slot_bit,
  input  logic [DATA_W-1:0] data_in,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_word
);

  function automatic logic [WORD_W-1:0] pack_word(input logic s,
                                                  input logic [DATA_W-1:0] d);
    return {s, d};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr   <= 1'b0;
      fifo_word <= '0;
    end else begin
      fifo_wr <= wr_req;
      if (wr_req) fifo_word <= pack_word(slot_bit, data_in);
    end
  end

  assert_wr_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !$past(wr_req, 2)) |=> !fifo_wr);

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ninth,
  input  logic              rx_perr,
  input  logic              mode_en,
  input  logic [DATA_W-1:0] station_addr,
  input  logic              lsi_en,
  input  logic              host_disable,
  input  logic              irq_ack,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_word,
  output logic              irq_flag
);

  mdf_evt_t evt;
  logic     rx_on;
  logic     accept;
  logic     slot_bit;
  logic     irq_set;

  mdf_classify #(.DATA_W(DATA_W)) u_classify (
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_ninth     (rx_ninth),
    .mode_en      (mode_en),
    .station_addr (station_addr),
    .evt          (evt)
  );

  mdf_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_match     (evt.match),
    .ev_mismatch  (evt.mismatch),
    .host_disable (host_disable),
    .rx_on        (rx_on)
  );

  // Named write decision and error-slot selection
  assign accept   = evt.bypass || evt.match || (evt.data && rx_on);
  assign slot_bit = evt.match ? rx_ninth : rx_perr;
  assign irq_set  = evt.match && lsi_en;

  mdf_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (irq_set),
    .ack      (irq_ack),
    .irq_flag (irq_flag)
  );

  mdf_wstage #(.DATA_W(DATA_W)) u_wstage (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (accept),
    .slot_bit  (slot_bit),
    .data_in   (rx_data),
    .fifo_wr   (fifo_wr),
    .fifo_word (fifo_word)
  );

  assert_wr_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid));

  assert_mismatch_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.mismatch |=> !fifo_wr);

  assert_addr_slot_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && $past(evt.match)) |-> fifo_word[DATA_W]);

  assert_off_data_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.data && !rx_on) |=> !fifo_wr);

  assert_bypass_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.bypass |=> (fifo_wr && fifo_word == {$past(rx_perr), $past(rx_data)}));

endmodule

// File: tb/sim_mdrop_addr_filter.sv
module sim_mdrop_addr_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ninth = 1'b0;
  logic       rx_perr = 1'b0;
  logic       mode_en = 1'b0;
  logic [7:0] station_addr = 8'hA5;
  logic       lsi_en = 1'b0;
  logic       host_disable = 1'b0;
  logic       irq_ack = 1'b0;
  logic       fifo_wr;
  logic [8:0] fifo_word;
  logic       irq_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  mdrop_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ninth(rx_ninth), .rx_perr(rx_perr), .mode_en(mode_en),
    .station_addr(station_addr), .lsi_en(lsi_en), .host_disable(host_disable),
    .irq_ack(irq_ack), .fifo_wr(fifo_wr), .fifo_word(fifo_word), .irq_flag(irq_flag)
  );

  // Vector layout: [22] mode [21] lsi [20] ninth [19] perr [18:11] data
  //                [10] exp_wr [9:1] exp_word [0] exp_irq   (station = A5)
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b0,8'h33, 1'b1,9'h033,1'b0}, // R2 ninth ignored
    {1'b0,1'b0,1'b0,1'b1,8'h44, 1'b1,9'h144,1'b0}, // R2 perr in slot
    {1'b1,1'b1,1'b0,1'b0,8'h55, 1'b0,9'h000,1'b0}, // R3 data while off
    {1'b1,1'b1,1'b1,1'b0,8'h5A, 1'b0,9'h000,1'b0}, // R3 other address
    {1'b1,1'b1,1'b1,1'b0,8'hA4, 1'b0,9'h000,1'b0}, // R12 one bit off
    {1'b1,1'b0,1'b1,1'b0,8'hA5, 1'b1,9'h1A5,1'b0}, // R5 R7 match, lsi off
    {1'b1,1'b0,1'b0,1'b1,8'h12, 1'b1,9'h112,1'b0}, // R4 R6 data perr=1
    {1'b1,1'b0,1'b0,1'b0,8'h34, 1'b1,9'h034,1'b0}, // R6 data perr=0
    {1'b1,1'b1,1'b1,1'b0,8'hA5, 1'b1,9'h1A5,1'b1}, // R9 R7 rematch
    {1'b1,1'b1,1'b0,1'b0,8'h56, 1'b1,9'h056,1'b1}, // R9 still on
    {1'b1,1'b1,1'b1,1'b1,8'h77, 1'b0,9'h000,1'b1}, // R8 other address
    {1'b1,1'b1,1'b0,1'b0,8'h78, 1'b0,9'h000,1'b1}, // R8 now off
    {1'b0,1'b1,1'b0,1'b0,8'h9A, 1'b1,9'h09A,1'b1}  // R2 mode off again
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs from a falling edge; outputs are then
  // sampled at the next falling edge, after the registering clock edge.
  task automatic step(input logic v, input logic m, input logic l,
                      input logic n, input logic p, input logic [7:0] d,
                      input logic hd, input logic ak);
    @(negedge clk);
    rx_valid = v; mode_en = m; lsi_en = l; rx_ninth = n; rx_perr = p;
    rx_data = d; host_disable = hd; irq_ack = ak;
    @(negedge clk);
    rx_valid = 1'b0; host_disable = 1'b0; irq_ack = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 5000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "fifo_wr in reset", {31'd0, fifo_wr}, 32'd0);
    chk("R1", "irq_flag in reset", {31'd0, irq_flag}, 32'd0);
    rst_n = 1'b1;
    // R1: receiver off after reset, data in filter mode dropped
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0);
    chk("R1", "data after reset", {31'd0, fifo_wr}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      step(1'b1, v[22], v[21], v[20], v[19], v[18:11], 1'b0, 1'b0);
      chk("R2-table", $sformatf("vec %0d wr", i), {31'd0, fifo_wr}, {31'd0, v[10]});
      if (v[10]) chk("R5/R6-table", $sformatf("vec %0d word", i), {23'd0, fifo_word}, {23'd0, v[9:1]});
      chk("R7-table", $sformatf("vec %0d irq", i), {31'd0, irq_flag}, {31'd0, v[0]});
      @(negedge clk);
      // R11: strobe lasts one cycle
      chk("R11", $sformatf("vec %0d strobe drop", i), {31'd0, fifo_wr}, 32'd0);
    end

    // R7: acknowledge clears the flag
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R7", "ack clears irq", {31'd0, irq_flag}, 32'd0);
    // R7: set and ack in the same cycle -> set
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1);
    chk("R7", "set beats ack", {31'd0, irq_flag}, 32'd1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    // R10: host disable turns receiver off
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h61, 1'b0, 1'b0);
    chk("R10", "data while on", {31'd0, fifo_wr}, 32'd1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R11", "no write without strobe", {31'd0, fifo_wr}, 32'd0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h62, 1'b0, 1'b0);
    chk("R10", "data after disable", {31'd0, fifo_wr}, 32'd0);
    // R10: disable together with matching address
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0);
    chk("R10", "match with disable written", {31'd0, fifo_wr}, 32'd1);
    chk("R10", "match with disable word", {23'd0, fifo_word}, 32'h1A5);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h63, 1'b0, 1'b0);
    chk("R10", "disable wins over turn-on", {31'd0, fifo_wr}, 32'd0);
    // R12: new station address, old one no longer matches
    station_addr = 8'h3C;
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0);
    chk("R12", "old address rejected", {31'd0, fifo_wr}, 32'd0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b0);
    chk("R12", "new address matched", {23'd0, fifo_word}, 32'h13C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule